// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog timer reached through a plain 32-bit register bus that completes every access in one clock cycle. Software picks a timeout from sixteen power-of-two lengths, sets it running, and must then keep writing a key word to a restart register. If that key write does not arrive in time, the watchdog raises its reset output, or first an interrupt. Once the watchdog is running, software cannot stop it. Only the block's own reset can do that.

Two 4-bit timeout codes are held. The first load after the enable uses the start-up code. Every later reload uses the steady-state code. A code k gives a period of 2^(BASE_EXP+k) clock cycles. BASE_EXP defaults to 16 and can be lowered so that simulation stays short.

The response-mode bit chooses what happens on expiry. In direct mode, expiry fires the reset pulse. In interrupt mode, the first expiry raises an interrupt, and the counter reloads and runs again. A second expiry while that interrupt is still pending fires the reset pulse.

Top module: `pulse_watchdog`

## Requirements
- R1: After reset, the control word (offset 0x00), the count (0x08) and the status (0x10) all read 0, and `sys_rst_o` and `irq_o` are low. Registers read through `rd_data_o` combinationally, the same cycle `addr_i` is driven.
- R2: A control write that sets bit 0 (enable) while the block is disabled makes the count read 2^(BASE_EXP+S)-1 after that clock edge. S is bits [7:4] of the range register at 0x04 (the start-up code).
- R3: From the edge that loads a period of P cycles, the expiry response is visible after edge P. The count decrements by one at each edge and expires on the edge where it reads 0.
- R4: Every reload after the enable, on expiry or on restart, loads 2^(BASE_EXP+T)-1. T is bits [3:0] of the range register (the steady-state code).
- R5: While enabled, writing exactly 32'h76 to offset 0x0C reloads the steady-state period at that edge.
- R6: A write to 0x0C with any other value is ignored, and the count keeps decrementing by one.
- R7: The enable bit is sticky. Writing 0 to control bit 0 leaves bit 0 reading 1, and the count keeps running.
- R8: `sys_rst_o` is a pulse that stays high for exactly RST_CYCLES clock cycles (8 by default).
- R9: With control bit 1 set (interrupt mode), the first expiry sets `irq_o` and status bit 0 and leaves `sys_rst_o` low.
- R10: A read cycle (`rd_en_i` high) at offset 0x14 clears the pending interrupt.
- R11: In interrupt mode, an expiry that occurs while the interrupt is still pending fires the reset pulse.
- R12: The count register is read-only. A write to 0x08 leaves its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe, one cycle |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe, needed for read side effects |
| rd_data_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Pending timeout interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
Most internal faults show up at the pins with little delay. A counter loaded with the wrong code is visible on the count register right after the enable edge. Its expiry then lands on the wrong cycle, which the bench measures edge by edge. A key filter that is too loose or a lost sticky enable shows up on the next readback, one cycle later. A wrong mode decision appears as the wrong output rising at the first or second expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_RANGE  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_KICK   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_ICLR   = 8'h14;

    localparam logic [DATA_W-1:0] KICK_KEY   = 32'h0000_0076;

    typedef logic [3:0] tcode_t;
endpackage

// File: rtl/wdog_reload.sv
module wdog_reload #(
    parameter int BASE_EXP = 16,
    localparam int CNT_W = BASE_EXP + 15
) (
    input  wdog_pkg::tcode_t   code_i,
    output logic [CNT_W-1:0]   reload_o
);
    // 2^(BASE_EXP+code)-1 is all ones shifted right by (15-code)
    logic [3:0] shift;
    always_comb begin
        shift    = 4'd15 - code_i;
        reload_o = {CNT_W{1'b1}} >> shift;
    end
endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
    parameter int RST_CYCLES = 8,
    localparam int PW = $clog2(RST_CYCLES + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    output logic active_o
);
    localparam logic [PW-1:0] LEN = PW'(RST_CYCLES);

    logic [PW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (fire_i)
            left_d = LEN;
        else if (left_q != '0)
            left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) left_q <= '0;
        else         left_q <= left_d;
    end

    assign active_o = (left_q != '0);
endmodule

// File: rtl/pulse_watchdog.sv
module pulse_watchdog
    import wdog_pkg::*;
#(
    parameter int BASE_EXP   = 16,
    parameter int RST_CYCLES = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [7:0]        addr_i,
    input  logic              wr_en_i,
    input  logic [31:0]       wr_data_i,
    input  logic              rd_en_i,
    output logic [31:0]       rd_data_o,
    output logic              irq_o,
    output logic              sys_rst_o
);
    localparam int CNT_W = BASE_EXP + 15;

    typedef struct packed {
        logic             en;
        logic             mode;
        tcode_t           init_code;
        tcode_t           run_code;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } wd_state_t;

    wd_state_t state_d, state_q;
    logic [CNT_W-1:0] init_reload, run_reload;
    logic fire;
    logic kick_hit;

    wdog_reload #(.BASE_EXP(BASE_EXP)) u_init_reload (
        .code_i  (state_q.init_code),
        .reload_o(init_reload)
    );

    wdog_reload #(.BASE_EXP(BASE_EXP)) u_run_reload (
        .code_i  (state_q.run_code),
        .reload_o(run_reload)
    );

    wdog_rst_stretch #(.RST_CYCLES(RST_CYCLES)) u_stretch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fire_i  (fire),
        .active_o(sys_rst_o)
    );

    always_comb begin
        state_d  = state_q;
        fire     = 1'b0;
        kick_hit = state_q.en && wr_en_i && (addr_i == OFF_KICK) && (wr_data_i == KICK_KEY);

        if (wr_en_i && addr_i == OFF_CTRL) begin
            state_d.mode = wr_data_i[1];
            if (wr_data_i[0] && !state_q.en) begin
                state_d.en  = 1'b1;
                state_d.cnt = init_reload;
            end
        end
        if (wr_en_i && addr_i == OFF_RANGE) begin
            state_d.run_code  = wr_data_i[3:0];
            state_d.init_code = wr_data_i[7:4];
        end
        if (rd_en_i && addr_i == OFF_ICLR)
            state_d.irq = 1'b0;

        if (state_q.en) begin
            if (kick_hit) begin
                state_d.cnt = run_reload;
            end else if (state_q.cnt == '0) begin
                state_d.cnt = run_reload;
                if (state_q.mode && !state_q.irq)
                    state_d.irq = 1'b1;
                else
                    fire = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            OFF_CTRL:   rd_data_o = {30'd0, state_q.mode, state_q.en};
            OFF_RANGE:  rd_data_o = {24'd0, state_q.init_code, state_q.run_code};
            OFF_COUNT:  rd_data_o = 32'(state_q.cnt);
            OFF_STATUS: rd_data_o = {31'd0, state_q.irq};
            OFF_ICLR:   rd_data_o = {31'd0, state_q.irq};
            default:    rd_data_o = '0;
        endcase
    end

    assign irq_o = state_q.irq;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int CNT_W      = 31,
    parameter int RST_CYCLES = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [7:0]       addr_i,
    input logic             wr_en_i,
    input logic [31:0]      wr_data_i,
    input logic             en_i,
    input logic             mode_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             irq_o,
    input logic             sys_rst_o
);
    int unsigned hi_len;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        hi_len <= 0;
        else if (sys_rst_o) hi_len <= hi_len + 1;
        else                hi_len <= 0;
    end

    // R7
    sticky_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(en_i) |-> en_i);

    // R1
    idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> cnt_i == '0);

    // R6
    bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && wr_en_i && addr_i == 8'h0C && wr_data_i != 32'h76 && cnt_i != '0)
        |=> cnt_i == $past(cnt_i) - 1'b1);

    // R3
    expiry_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && cnt_i == '0 && !(wr_en_i && addr_i == 8'h0C && wr_data_i == 32'h76))
        |=> (sys_rst_o || irq_o));

    // R8
    pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sys_rst_o) |-> hi_len == RST_CYCLES);

    // R11
    second_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(sys_rst_o) && $past(mode_i)) |-> $past(irq_o));

    // R9
    irq_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> !$rose(sys_rst_o));
endmodule

bind pulse_watchdog wdog_chk #(
    .CNT_W     (BASE_EXP + 15),
    .RST_CYCLES(RST_CYCLES)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .en_i     (state_q.en),
    .mode_i   (state_q.mode),
    .cnt_i    (state_q.cnt),
    .irq_o    (irq_o),
    .sys_rst_o(sys_rst_o)
);

// File: tb/pulse_watchdog_tb.sv
module pulse_watchdog_tb_top;
    localparam int B = 4;
    localparam int PULSE = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq, sys_rst;

    int checks = 0;
    int errs = 0;
    int cyc;

    always #5 clk = ~clk;

    pulse_watchdog #(.BASE_EXP(B), .RST_CYCLES(PULSE)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .irq_o(irq), .sys_rst_o(sys_rst)
    );

    // start-up code in [7:4], steady-state code in [3:0]
    localparam logic [7:0] VEC [4] = '{8'h01, 8'h10, 8'h21, 8'h03};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
    endtask

    task automatic wait_rst(input int limit);
        while (!sys_rst && cyc < limit) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int p0, p1, w, c0;

        // R1 reset state
        do_reset();
        rd(8'h00, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(8'h08, v); chk(v == 0, "R1 count", v, 0);
        rd(8'h10, v); chk(v == 0, "R1 status", v, 0);
        chk(!sys_rst && !irq, "R1 outputs", {sys_rst, irq}, 0);

        // R12 write to count is ignored
        wr(8'h08, 32'hFFFF);
        rd(8'h08, v); chk(v == 0, "R12 count write", v, 0);

        // table: direct-mode timing for several code pairs
        foreach (VEC[i]) begin
            do_reset();
            p0 = 1 << (B + VEC[i][7:4]);
            p1 = 1 << (B + VEC[i][3:0]);
            wr(8'h04, {24'd0, VEC[i]});
            wr(8'h00, 32'h1);
            cyc = 0;
            rd(8'h08, v); chk(v == p0 - 1, "R2 initial load", v, p0 - 1);
            wait_rst(5000);
            chk(cyc == p0, "R3 first expiry", cyc, p0);
            w = 0;
            while (sys_rst && w < 50) begin w++; tick(); end
            chk(w == PULSE, "R8 pulse width", w, PULSE);
            wait_rst(5000);
            chk(cyc == p0 + p1, "R4 steady reload", cyc, p0 + p1);
        end

        // R6 / R5 / R7: key filtering and sticky enable
        do_reset();
        wr(8'h04, 32'h21);
        wr(8'h00, 32'h1);
        repeat (10) @(negedge clk);
        wr(8'h0C, 32'h75);
        rd(8'h08, v); chk(v == 52, "R6 bad key ignored", v, 52);
        wr(8'h0C, 32'h176);
        rd(8'h08, v); chk(v == 51, "R6 wide bad key ignored", v, 51);
        wr(8'h0C, 32'h76);
        cyc = 0;
        rd(8'h08, v); chk(v == 31, "R5 key reload", v, 31);
        wr(8'h00, 32'h0); cyc++;
        rd(8'h00, v); chk(v[0] == 1'b1, "R7 enable sticky", v[0], 1);
        rd(8'h08, v); chk(v == 30, "R7 count runs", v, 30);
        wait_rst(5000);
        chk(cyc == 32, "R5 expiry after key", cyc, 32);

        // interrupt mode: R9 / R10 / R11
        do_reset();
        wr(8'h04, 32'h00);
        wr(8'h00, 32'h3);
        cyc = 0;
        while (!irq && !sys_rst && cyc < 5000) tick();
        chk(cyc == 16 && irq, "R9 irq on first expiry", cyc, 16);
        chk(!sys_rst, "R9 no reset", sys_rst, 0);
        rd(8'h10, v); chk(v == 1, "R9 status bit", v, 1);
        addr = 8'h14; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        chk(!irq, "R10 read clears irq", irq, 0);
        rd(8'h10, v); chk(v == 0, "R10 status cleared", v, 0);
        while (!irq && !sys_rst && cyc < 5000) tick();
        chk(cyc == 32 && irq && !sys_rst, "R9 irq again after clear", cyc, 32);
        c0 = cyc;
        wait_rst(5000);
        chk(cyc == c0 + 16, "R11 reset on second expiry", cyc, c0 + 16);
        chk(irq, "R11 irq still pending", irq, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end
endmodule